// File: doc/BRIEF.md
# Ripple-Chained 32-bit ALU

This block is a purely combinational arithmetic and logic unit built from identical one-bit cells chained by their carries. Every cell forms the AND and the OR of its operand bits, contains a full adder, can invert its B bit, and picks its result bit from four candidates with a 2-bit operation index. A 3-bit control word selects the function: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than.

No comparator is used for set-on-less-than. The top cell's adder output is corrected for overflow into a single "set" bit. That bit is routed back as the fourth mux candidate of cell 0, and the fourth candidate of every other cell is tied low. Besides the result, the block reports a zero flag, a two's-complement overflow flag and the set bit itself. A datapath places it between the register-file read ports and the write-back mux, and the branch logic uses the zero flag.

Top module: `ripple_alu`

## Requirements
- R1: Control 3'b000 (bit 2 = invert-B, bits 1:0 = operation index) drives result = A AND B.
- R2: Control 3'b001 drives result = A OR B.
- R3: Control 3'b010 drives result = (A + B) mod 2^32.
- R4: Control 3'b110 drives result = (A − B) mod 2^32. Carry-in of cell 0 equals the invert-B bit, so A + ~B + 1 is formed.
- R5: Control 3'b111 drives result bit 0 = 1 exactly when A < B as signed 32-bit values, and bits 31:1 = 0. This holds also when A − B overflows.
- R6: zero_o is 1 exactly when all 32 result bits are 0, for every control value.
- R7: With control 3'b010, ovf_o is 1 exactly when A and B have the same sign and the sign of the 32-bit sum differs from it.
- R8: With control 3'b110, ovf_o is 1 exactly when A and B have different signs and the sign of the 32-bit difference differs from the sign of A.
- R9: With invert-B set and operation index 0 or 1 (controls 3'b100 and 3'b101), result is A AND NOT B or A OR NOT B.
- R10: set_o is the true sign of the unbounded signed sum A + (invert-B ? −B : B), that is, the MSB sum bit XOR overflow. With control 3'b011, result = {31'b0, set_o}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ctrl_i | input | 3 | {invert-B, operation index[1:0]} |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | All result bits are zero |
| ovf_o | output | 1 | Signed overflow of the adder chain |
| set_o | output | 1 | Overflow-corrected sign of the adder chain |

## Verification
The block holds no state, so a wrong internal net shows at the ports in the same evaluation as the operands. A broken carry link only shows when a carry actually travels through that cell. For this reason the operands include long carry runs (all-ones plus one, zero minus one) as well as random values. A wrong feedback of the set bit, or a missing overflow correction, only appears in set-on-less-than on operands whose difference overflows. Those pairs are applied on purpose. The zero flag is checked against results that are zero and results that have a single bit set, at both ends of the word.

// File: rtl/ripple_alu_pkg.sv
// Package: control codes shared by the ALU and its users.
// Assumes bit 2 is invert-B and bits 1:0 index the cell result mux.
package ripple_alu_pkg;
    typedef enum logic [2:0] {
        CTRL_AND = 3'b000,
        CTRL_OR  = 3'b001,
        CTRL_ADD = 3'b010,
        CTRL_SUB = 3'b110,
        CTRL_SLT = 3'b111
    } alu_ctrl_e;

    localparam int unsigned MUX_AND  = 0;
    localparam int unsigned MUX_OR   = 1;
    localparam int unsigned MUX_SUM  = 2;
    localparam int unsigned MUX_LESS = 3;
endpackage

// File: rtl/alu_bit_slice.sv
// One-bit ALU cell: optional B inversion, AND, OR, full adder and a
// 4-way result mux indexed by op_i. Assumes the carry chain is acyclic.
module alu_bit_slice
    import ripple_alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       carry_i,
    input  logic       binv_i,
    input  logic [1:0] op_i,
    input  logic       less_i,
    output logic       res_o,
    output logic       sum_o,
    output logic       carry_o
);
    logic b_sel;
    logic and_bit;
    logic or_bit;

    // Purpose: operand conditioning, logic gates and full adder.
    always_comb begin
        b_sel   = binv_i ? ~b_i : b_i;
        and_bit = a_i & b_sel;
        or_bit  = a_i | b_sel;
        sum_o   = a_i ^ b_sel ^ carry_i;
        carry_o = (a_i & b_sel) | (carry_i & (a_i ^ b_sel));
    end

    // Purpose: pick this cell's result bit.
    always_comb begin
        unique case (op_i)
            2'(MUX_AND): res_o = and_bit;
            2'(MUX_OR):  res_o = or_bit;
            2'(MUX_SUM): res_o = sum_o;
            default:     res_o = less_i;
        endcase
    end
endmodule

// File: rtl/alu_msb_flags.sv
// Sign-cell flag logic: overflow from the carries around the top cell,
// and the overflow-corrected sign used for set-on-less-than.
module alu_msb_flags (
    input  logic carry_into_msb_i,
    input  logic carry_out_msb_i,
    input  logic sum_msb_i,
    output logic ovf_o,
    output logic set_o
);
    // Purpose: derive overflow and the true sign of the adder result.
    always_comb begin
        ovf_o = carry_into_msb_i ^ carry_out_msb_i;
        set_o = sum_msb_i ^ ovf_o;
    end
endmodule

// File: rtl/alu_zero_detect.sv
// Zero detector: high when every bit of the word is low.
module alu_zero_detect #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             zero_o
);
    // Purpose: reduce the word to one flag.
    always_comb zero_o = ~(|word_i);
endmodule

// File: rtl/ripple_alu.sv
// Top: WIDTH one-bit cells in a ripple-carry chain. The set bit of the
// sign cell loops back to cell 0's less input; the others see 0.
// Assumes WIDTH >= 2. Purely combinational, so it has no clock or reset.
module ripple_alu
    import ripple_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    input  logic [2:0]  ctrl_i,
    output logic [31:0] result_o,
    output logic        zero_o,
    output logic        ovf_o,
    output logic        set_o
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH:0]   carry_w;
    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] res_w;
    logic             binv;
    logic [1:0]       op_idx;

    // Purpose: split the control word.
    always_comb begin
        binv   = ctrl_i[2];
        op_idx = ctrl_i[1:0];
    end

    assign carry_w[0] = binv;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_cell
            logic less_in;
            if (gi == 0) begin : g_lsb
                assign less_in = set_o;
            end else begin : g_rest
                assign less_in = 1'b0;
            end
            alu_bit_slice u_cell (
                .a_i     (a_i[gi]),
                .b_i     (b_i[gi]),
                .carry_i (carry_w[gi]),
                .binv_i  (binv),
                .op_i    (op_idx),
                .less_i  (less_in),
                .res_o   (res_w[gi]),
                .sum_o   (sum_w[gi]),
                .carry_o (carry_w[gi+1])
            );
        end
    endgenerate

    alu_msb_flags u_flags (
        .carry_into_msb_i (carry_w[MSB]),
        .carry_out_msb_i  (carry_w[WIDTH]),
        .sum_msb_i        (sum_w[MSB]),
        .ovf_o            (ovf_o),
        .set_o            (set_o)
    );

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .word_i (res_w),
        .zero_o (zero_o)
    );

    assign result_o = res_w;

    // Purpose: guard the chain against behavioural arithmetic.
    always_comb begin
        // R1
        and_result_chk: assert (ctrl_i != CTRL_AND || result_o == (a_i & b_i))
            else $error("and result mismatch");
        // R3
        add_chain_chk: assert (binv || sum_w == a_i + b_i)
            else $error("adder chain sum mismatch");
        // R4
        sub_chain_chk: assert (!binv || sum_w == a_i - b_i)
            else $error("subtract chain mismatch");
        // R5
        slt_result_chk: assert (ctrl_i != CTRL_SLT ||
                                result_o == {31'b0, ($signed(a_i) < $signed(b_i))})
            else $error("set-on-less-than mismatch");
        // R7
        add_overflow_chk: assert (ctrl_i != CTRL_ADD ||
                                  ovf_o == ((a_i[31] == b_i[31]) && (result_o[31] != a_i[31])))
            else $error("add overflow mismatch");
        // R6
        zero_flag_chk: assert (!zero_o || result_o == 32'd0)
            else $error("zero flag set on nonzero result");
    end
endmodule

// File: tb/ripple_alu_bench.sv
module ripple_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a, b;
    logic [2:0]  ctrl;
    logic [31:0] result;
    logic        zero, ovf, set_b;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    ripple_alu u_ripple_alu (
        .a_i(a), .b_i(b), .ctrl_i(ctrl),
        .result_o(result), .zero_o(zero), .ovf_o(ovf), .set_o(set_b)
    );

    function automatic logic true_lt(input logic [31:0] x, input logic [31:0] y);
        return $signed(x) < $signed(y);
    endfunction

    function automatic logic sum_sign(input logic [31:0] x, input logic [31:0] y);
        logic [32:0] s;
        s = {x[31], x} + {y[31], y};
        return s[32];
    endfunction

    function automatic logic [31:0] exp_result(input logic [31:0] x, input logic [31:0] y,
                                               input logic [2:0] c);
        case (c)
            3'b000:  return x & y;
            3'b001:  return x | y;
            3'b010:  return x + y;
            3'b110:  return x - y;
            3'b111:  return {31'b0, true_lt(x, y)};
            3'b100:  return x & ~y;
            3'b101:  return x | ~y;
            default: return {31'b0, sum_sign(x, y)};
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [31:0] x, input logic [31:0] y,
                                     input logic sub);
        logic [31:0] r;
        r = sub ? x - y : x + y;
        if (sub) return (x[31] != y[31]) && (r[31] != x[31]);
        return (x[31] == y[31]) && (r[31] != x[31]);
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            3'b011:  return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s a=%h b=%h ctrl=%b actual=%h expected=%h",
                     req, what, a, b, ctrl, act, exp);
        end
    endtask

    task automatic run_vec(input logic [31:0] x, input logic [31:0] y, input logic [2:0] c);
        logic [31:0] er;
        @(negedge clk);
        a = x; b = y; ctrl = c;
        @(posedge clk);
        er = exp_result(x, y, c);
        check(tag_of(c), "result", result, er);
        check("R6", "zero", {31'b0, zero}, {31'b0, (er == 32'd0)});
        check("R10", "set", {31'b0, set_b},
              {31'b0, (c[2] ? true_lt(x, y) : sum_sign(x, y))});
        if (c == 3'b010) check("R7", "ovf", {31'b0, ovf}, {31'b0, exp_ovf(x, y, 1'b0)});
        if (c == 3'b110) check("R8", "ovf", {31'b0, ovf}, {31'b0, exp_ovf(x, y, 1'b1)});
    endtask

    task automatic all_ctrl(input logic [31:0] x, input logic [31:0] y);
        for (int k = 0; k < 8; k++) run_vec(x, y, 3'(k));
    endtask

    initial begin
        a = '0; b = '0; ctrl = 3'b000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero operands, AND selected (R1, R6)
        check("R1", "idle result", result, 32'd0);
        check("R6", "idle zero", {31'b0, zero}, 32'd1);
        // Directed corners
        all_ctrl(32'h7FFF_FFFF, 32'h0000_0001);   // R7 add overflow
        all_ctrl(32'h8000_0000, 32'h0000_0001);   // R5/R8 slt with overflow
        all_ctrl(32'h7FFF_FFFF, 32'hFFFF_FFFF);   // R5/R8 opposite overflow
        all_ctrl(32'hFFFF_FFFF, 32'h0000_0001);   // R3 full carry run
        all_ctrl(32'h0000_0000, 32'h0000_0001);   // R4 borrow run
        all_ctrl(32'h8000_0000, 32'h8000_0000);   // R6 add to zero, R7
        all_ctrl(32'h1234_5678, 32'h1234_5678);   // R6 equal, slt=0
        all_ctrl(32'h0000_0001, 32'h0000_0000);   // R6 single low bit
        all_ctrl(32'h8000_0000, 32'h0000_0000);   // R6 single top bit
        all_ctrl(32'hA5A5_A5A5, 32'h5A5A_5A5A);   // R1/R2/R9 patterns
        // Constrained random
        void'($urandom(32'd20240611));
        for (int n = 0; n < 600; n++) begin
            logic [31:0] x, y;
            x = $urandom();
            y = $urandom();
            if (n % 5 == 0) y = x;
            if (n % 7 == 0) x[31] = ~y[31];
            all_ctrl(x, y);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule